// File: doc/BRIEF.md
# Outer-Product Accumulation Array

This block forms the 3×3 product of two 3×64 signal blocks, one times the transpose of the other. It does this by adding up 64 outer products. Each period it accepts one column from each operand on a valid/ready stream. It then spends three clock cycles on that column. In each of those cycles, three shared signed multipliers produce one row of the outer product, and that row is added into a 3×3 grid of wide accumulators.

A `start` pulse clears the grid and opens a new block. After the 64th column has been folded in, `done` pulses for one cycle and the stream stops accepting columns. The nine results then stay readable through an addressed read port until the next `start`. Each result is rounded to 16 bits and saturated. The stream follows the usual rules. A column transfers on a clock edge where both `col_valid` and `col_ready` are high. The source may hold `col_valid` low for any number of cycles. `col_ready` is low while no block is open, and it is low for the first two cycles of each column's three-cycle period. At full rate the array therefore takes one column every third cycle.

Top module: `outer_acc_array`

## Requirements
- R1: After reset, `col_ready` and `done` are low and all nine results read as 0.
- R2: A `start` pulse clears all nine accumulators, and `col_ready` is high in the cycle after it.
- R3: After a column is accepted, `col_ready` is low for the next two cycles and high in the third, so columns can follow each other every three cycles.
- R4: Operand element i sits in bits [16i+15:16i] of `col_a` and `col_b`. Result (row i, column j), read with `rd_row`=i and `rd_col`=j, equals S = Σ a_i·b_j over the block's columns, formed as floor((S + 128) / 256) (8 fraction bits, ties rounded upward) and saturated to a signed 16-bit value.
- R5: `done` is high for exactly one cycle, in the cycle after the last multiply cycle of the 64th column. After it, `col_ready` stays low and the results hold.
- R6: Cycles with `col_valid` low stall the array without changing any partial sum. A block fed with gaps gives the same results as one fed back to back.
- R7: Columns offered while no block is open (before the first `start`, or after `done`) are not accepted and leave the results unchanged.
- R8: A sum whose rounded value is above 32767 reads as 32767, and one below −32768 reads as −32768.
- R9: A `start` during an open block abandons it. The new block's results contain none of the abandoned columns.
- R10: With columns supplied back to back, `done` rises 192 clock cycles after the edge that accepts the first column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the accumulators and opens a block |
| col_valid | input | 1 | Column pair on `col_a`/`col_b` is valid |
| col_ready | output | 1 | Array can accept a column this cycle |
| col_a | input | 48 | Three signed 16-bit elements of the first operand column |
| col_b | input | 48 | Three signed 16-bit elements of the second operand column |
| done | output | 1 | One-cycle pulse when the block is complete |
| rd_row | input | 2 | Result row select |
| rd_col | input | 2 | Result column select |
| rd_data | output | 16 | Rounded, saturated result at (`rd_row`, `rd_col`) |

## Verification
The hardest case to reach is the third cycle of the 64th period. Here the sequencer must finish the block and raise `done` while a column is still being offered. That column must not be taken in as a 65th product. The bench reaches this case by holding `col_valid` high straight through the end of the block. It then checks that the results held and that `col_ready` stayed low. Saturation at both rails and exact rounding ties need operands that push sums far past 16 bits or land exactly on half a step. These come from dedicated blocks with extreme and tie-producing operands, next to pseudo-random blocks fed with stall gaps and a block restarted midway.

// File: rtl/outer_acc_pkg.sv
package outer_acc_pkg;
  localparam int unsigned OA_DIM    = 3;
  localparam int unsigned OA_DATA_W = 16;
  localparam int unsigned OA_COLS   = 64;
  localparam int unsigned OA_ACC_W  = 40;
  localparam int unsigned OA_FRAC_W = 8;
endpackage

// File: rtl/oacc_ctrl.sv
module oacc_ctrl #(
  parameter int unsigned DIM  = 3,
  parameter int unsigned COLS = 64,
  localparam int unsigned PH_W  = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int unsigned CNT_W = $clog2(COLS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            col_valid,
  output logic            col_ready,
  output logic            load,
  output logic            busy,
  output logic [PH_W-1:0] phase,
  output logic            done
);
  logic             running_q;
  logic             busy_q;
  logic [PH_W-1:0]  phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last_ph;
  logic             last_col;

  assign last_ph   = busy_q && (phase_q == PH_W'(DIM - 1));
  assign last_col  = (cnt_q == CNT_W'(COLS - 1));
  // the final period hands over no further column
  assign col_ready = running_q && (!busy_q || (last_ph && !last_col));
  assign load      = col_valid && col_ready && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      busy_q    <= 1'b0;
      phase_q   <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        running_q <= 1'b1;
        busy_q    <= 1'b0;
        phase_q   <= '0;
        cnt_q     <= '0;
      end else begin
        if (last_ph) begin
          if (last_col) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
            done_q    <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        if (load) begin
          busy_q  <= 1'b1;
          phase_q <= '0;
        end else if (busy_q) begin
          if (last_ph) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy  = busy_q;
  assign phase = phase_q;
  assign done  = done_q;
endmodule

// File: rtl/oacc_mulrow.sv
module oacc_mulrow #(
  parameter int unsigned DIM    = 3,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PH_W   = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int unsigned PROD_W = 2 * DATA_W,
  localparam int unsigned VEC_W  = DIM * DATA_W
) (
  input  logic [VEC_W-1:0]      a_vec,
  input  logic [VEC_W-1:0]      b_vec,
  input  logic [PH_W-1:0]       phase,
  output logic [DIM*PROD_W-1:0] prod
);
  logic signed [DATA_W-1:0] a_sel;

  always_comb begin
    a_sel = '0;
    for (int k = 0; k < DIM; k++) begin
      if (phase == PH_W'(k)) a_sel = a_vec[k*DATA_W +: DATA_W];
    end
  end

  for (genvar j = 0; j < DIM; j++) begin : g_mul
    logic signed [DATA_W-1:0] b_el;
    logic signed [PROD_W-1:0] p;
    assign b_el = b_vec[j*DATA_W +: DATA_W];
    assign p    = a_sel * b_el;
    assign prod[j*PROD_W +: PROD_W] = p;
  end
endmodule

// File: rtl/oacc_grid.sv
module oacc_grid #(
  parameter int unsigned DIM    = 3,
  parameter int unsigned PROD_W = 32,
  parameter int unsigned ACC_W  = 40,
  localparam int unsigned PH_W  = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      en,
  input  logic [PH_W-1:0]           phase,
  input  logic [DIM*PROD_W-1:0]     prod,
  output logic [DIM*DIM*ACC_W-1:0]  acc_flat
);
  for (genvar i = 0; i < DIM; i++) begin : g_row
    for (genvar j = 0; j < DIM; j++) begin : g_pe
      logic signed [ACC_W-1:0]  acc_q;
      logic signed [PROD_W-1:0] p;
      assign p = prod[j*PROD_W +: PROD_W];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             acc_q <= '0;
        else if (clear)                         acc_q <= '0;
        else if (en && (phase == PH_W'(i)))     acc_q <= acc_q + ACC_W'(p);
      end
      assign acc_flat[(i*DIM+j)*ACC_W +: ACC_W] = acc_q;
    end
  end
endmodule

// File: rtl/oacc_readout.sv
module oacc_readout #(
  parameter int unsigned DIM    = 3,
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned IDX_W = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic [DIM*DIM*ACC_W-1:0] acc_flat,
  input  logic [IDX_W-1:0]         rd_row,
  input  logic [IDX_W-1:0]         rd_col,
  output logic [DATA_W-1:0]        rd_data
);
  localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) << (FRAC_W - 1);
  localparam logic signed [ACC_W:0] MAXV = {{(ACC_W-DATA_W+2){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] MINV = ~MAXV;

  logic signed [ACC_W-1:0] sel;
  logic signed [ACC_W:0]   ext;
  logic signed [ACC_W:0]   rnd;

  always_comb begin
    sel = '0;
    for (int r = 0; r < DIM; r++) begin
      for (int c = 0; c < DIM; c++) begin
        if (rd_row == IDX_W'(r) && rd_col == IDX_W'(c))
          sel = acc_flat[(r*DIM+c)*ACC_W +: ACC_W];
      end
    end
    ext = {sel[ACC_W-1], sel};
    rnd = (ext + HALF) >>> FRAC_W;
    if (rnd > MAXV)      rd_data = MAXV[DATA_W-1:0];
    else if (rnd < MINV) rd_data = MINV[DATA_W-1:0];
    else                 rd_data = rnd[DATA_W-1:0];
  end
endmodule

// File: rtl/outer_acc_array.sv
module outer_acc_array
  import outer_acc_pkg::*;
#(
  parameter int unsigned DIM    = OA_DIM,
  parameter int unsigned DATA_W = OA_DATA_W,
  parameter int unsigned COLS   = OA_COLS,
  parameter int unsigned ACC_W  = OA_ACC_W,
  parameter int unsigned FRAC_W = OA_FRAC_W,
  localparam int unsigned VEC_W  = DIM * DATA_W,
  localparam int unsigned IDX_W  = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              col_valid,
  output logic              col_ready,
  input  logic [VEC_W-1:0]  col_a,
  input  logic [VEC_W-1:0]  col_b,
  output logic              done,
  input  logic [IDX_W-1:0]  rd_row,
  input  logic [IDX_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned PH_W   = (DIM > 1) ? $clog2(DIM) : 1;

  logic                     load;
  logic                     busy;
  logic [PH_W-1:0]          phase;
  logic [VEC_W-1:0]         a_q;
  logic [VEC_W-1:0]         b_q;
  logic [DIM*PROD_W-1:0]    prod;
  logic [DIM*DIM*ACC_W-1:0] acc_flat;

  oacc_ctrl #(.DIM(DIM), .COLS(COLS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .col_valid(col_valid),
    .col_ready(col_ready), .load(load), .busy(busy), .phase(phase), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= col_a;
      b_q <= col_b;
    end
  end

  oacc_mulrow #(.DIM(DIM), .DATA_W(DATA_W)) mul_i (
    .a_vec(a_q), .b_vec(b_q), .phase(phase), .prod(prod)
  );

  oacc_grid #(.DIM(DIM), .PROD_W(PROD_W), .ACC_W(ACC_W)) grid_i (
    .clk(clk), .rst_n(rst_n), .clear(start), .en(busy), .phase(phase),
    .prod(prod), .acc_flat(acc_flat)
  );

  oacc_readout #(.DIM(DIM), .ACC_W(ACC_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) rd_i (
    .acc_flat(acc_flat), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );
endmodule

// File: rtl/outer_acc_chk.sv
module outer_acc_chk #(
  parameter int unsigned FLAT_W = 360
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              col_valid,
  input logic              col_ready,
  input logic              done,
  input logic              busy,
  input logic [FLAT_W-1:0] acc_flat
);
  // R2: start leaves every accumulator at zero
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc_flat == '0));

  // R3: an accepted column blocks the next transfer
  p_gap_after_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && !start) |=> !col_ready);

  // R5: done lasts a single cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5, R7: no transfer once the block has closed
  p_closed_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |-> !col_ready);

  // R6: idle cycles keep every partial sum
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(acc_flat));
endmodule

bind outer_acc_array outer_acc_chk #(.FLAT_W(DIM*DIM*ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .col_valid(col_valid),
  .col_ready(col_ready), .done(done), .busy(busy), .acc_flat(acc_flat)
);

// File: tb/outer_acc_array_tb_top.sv
`timescale 1ns/1ps
module outer_acc_array_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        col_valid = 1'b0;
  logic        col_ready;
  logic [47:0] col_a = '0;
  logic [47:0] col_b = '0;
  logic        done;
  logic [1:0]  rd_row = '0;
  logic [1:0]  rd_col = '0;
  logic [15:0] rd_data;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 1'b0;
  longint model [3][3];
  time   t_first;

  always #10 clk = ~clk;

  outer_acc_array dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .col_valid(col_valid),
    .col_ready(col_ready), .col_a(col_a), .col_b(col_b), .done(done),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expect_rd(input longint s);
    longint r;
    r = (s + 128) >>> 8;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) model[i][j] = 0;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        rd_row = 2'(i);
        rd_col = 2'(j);
        #1;
        chk(req, longint'($signed(rd_data)), expect_rd(model[i][j]));
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    clear_model();
  endtask

  task automatic send(input logic [47:0] av, input logic [47:0] bv, input int gap, input bit first);
    for (int g = 0; g < gap; g++) @(negedge clk);
    @(negedge clk);
    col_valid = 1'b1;
    col_a = av;
    col_b = bv;
    while (!col_ready) @(negedge clk);
    @(posedge clk);
    if (first) t_first = $time;
    #1;
    col_valid = 1'b0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        model[i][j] += longint'($signed(av[i*16 +: 16])) * longint'($signed(bv[j*16 +: 16]));
  endtask

  function automatic logic [15:0] pv(input int s);
    int t;
    t = s * 1103515245 + 12345;
    return t[23:8];
  endfunction

  task automatic make_col(input int mode, input int seed, input int c,
                          output logic [47:0] av, output logic [47:0] bv);
    for (int e = 0; e < 3; e++) begin
      case (mode)
        1: begin av[e*16 +: 16] = 16'h8000;
                 bv[e*16 +: 16] = (e == 0) ? 16'h8000 : (e == 1) ? 16'h7FFF : 16'h0001; end
        2: begin av[e*16 +: 16] = 16'(e + 1);
                 bv[e*16 +: 16] = (e == 0) ? 16'd2 : (e == 1) ? 16'hFFFE : 16'd1; end
        default: begin av[e*16 +: 16] = pv(seed + c * 7 + e);
                       bv[e*16 +: 16] = pv(seed * 3 + c * 11 + e + 100); end
      endcase
    end
  endtask

  // feeds a whole block; gaps select stalls between columns
  task automatic run_block(input int mode, input int seed, input bit gaps, input string req);
    logic [47:0] av, bv;
    time t_done;
    pulse_start();
    chk("R2 ready after start", longint'(col_ready), 1);
    for (int c = 0; c < 64; c++) begin
      make_col(mode, seed, c, av, bv);
      send(av, bv, gaps ? (c % 4) : 0, c == 0);
    end
    @(negedge clk);
    while (!done) @(negedge clk);
    t_done = $time;
    if (!gaps) chk("R10 cycles to done", longint'((t_done - t_first - 10) / 20), 192);
    @(negedge clk);
    chk("R5 done single cycle", longint'(done), 0);
    chk("R5 ready low after done", longint'(col_ready), 0);
    read_all(req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [47:0] av, bv;
    clear_model();
    repeat (3) @(negedge clk);
    chk("R1 ready at reset", longint'(col_ready), 0);
    chk("R1 done at reset", longint'(done), 0);
    read_all("R1 results zero at reset");
    rst_n = 1'b1;

    // R7 before any start
    @(negedge clk);
    col_valid = 1'b1;
    col_a = {3{16'h1234}};
    col_b = {3{16'h4321}};
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R7 no ready before start", longint'(col_ready), 0);
    end
    col_valid = 1'b0;
    read_all("R7 results unchanged before start");

    // R3 ready spacing, then finish block continuously
    pulse_start();
    make_col(0, 5, 0, av, bv);
    send(av, bv, 0, 1'b1);
    @(negedge clk); chk("R3 ready low cycle 1", longint'(col_ready), 0);
    @(negedge clk); chk("R3 ready low cycle 2", longint'(col_ready), 0);
    @(negedge clk); chk("R3 ready high cycle 3", longint'(col_ready), 1);
    for (int c = 1; c < 64; c++) begin
      make_col(0, 5, c, av, bv);
      send(av, bv, 0, 1'b0);
    end
    @(negedge clk);
    while (!done) @(negedge clk);
    @(negedge clk);
    read_all("R4 pattern block");

    // more pseudo-random blocks, back-to-back and stalled
    run_block(0, 17, 1'b0, "R4 dense block");
    run_block(0, 29, 1'b1, "R6 stalled block");
    run_block(0, 29, 1'b0, "R6 same block no stalls");
    run_block(2, 0, 1'b1, "R4 rounding ties");
    run_block(1, 0, 1'b0, "R8 saturation");

    // R7 after done, with valid held across the block end
    pulse_start();
    for (int c = 0; c < 64; c++) begin
      make_col(0, 41, c, av, bv);
      send(av, bv, 0, c == 0);
      if (c == 63) col_valid = 1'b1;
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k > 3) chk("R7 no ready after done", longint'(col_ready), 0);
    end
    col_valid = 1'b0;
    read_all("R7 results held after done");

    // R9 abandon a block midway
    pulse_start();
    for (int c = 0; c < 10; c++) begin
      make_col(0, 77, c, av, bv);
      send(av, bv, 0, c == 0);
    end
    run_block(0, 91, 1'b0, "R9 restart discards old columns");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule